// File: doc/BRIEF.md
# Configurable-Width Write Demultiplexer with Byte Mask

This block sits on the write side of a memory device whose external data width can be changed at run time. Write data arrives as a 16-lane by 16-slot packet. Each lane carries one bit per time slot. Only the lanes that belong to the active width carry meaningful data. The block places those lanes into the correct region of a 256-bit internal core bus. That bus is organised as 16 sets of 16 bits, and one lane fills one set over the 16 slots of a packet. The block also produces one write enable per core byte. These enables combine the placement with an 8-bit byte mask.

A 3-bit width code selects how many lanes are live: 1, 2, 4, 8 or 16. A 4-bit sub-column address from the column command acts as an extra column address. It picks which aligned block of sets receives the live lanes. The sub-column bits below the block size are ignored. Outputs are registered and appear one clock after the valid strobe.

Top module: `wdm_write_demux`

## Requirements
- R1: While `rst_ni` is low and after its release with no strobe, `valid_o` is 0, `core_we_o` is all zero and `core_data_o` is all zero.
- R2: `valid_o` equals `valid_i` from the previous clock. A cycle without a strobe yields all-zero data and enables on the next cycle.
- R3: Width code 3'b100 (x16) maps lane L (`wdata_i[16L+t]`, slot t) to set L (`core_data_o[16L+t]`) for all 16 lanes, and the sub-column is ignored.
- R4: Width code 3'b011 (x8) places lanes 0..7 into sets 8*sc[3]..8*sc[3]+7, and sc[2:0] is ignored.
- R5: Width code 3'b010 (x4) places lanes 0..3 into the 64-bit block of sets 4*sc[3:2]..4*sc[3:2]+3.
- R6: Width code 3'b001 (x2) places lanes 0..1 into sets 2*sc[3:1] and 2*sc[3:1]+1. Sub-column bit 0 and lanes 2..15 have no effect on any output.
- R7: Width code 3'b000 (x1) places lane 0 into set sc[3:0].
- R8: Every set outside the selected block has data 0 and both of its byte enables at 0.
- R9: Core byte b is bits `[8b+7:8b]` of `core_data_o`, where set s holds bytes 2s (slots 0..7) and 2s+1 (slots 8..15). Its enable `core_we_o[b]` is 1 only when its set is placed and `mask_i[b mod 8]` is 0. The mask never alters data.
- R10: Width codes 3'b101..3'b111 are reserved. They give no enables and all-zero data, while `valid_o` still follows the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Write packet strobe |
| width_i | input | 3 | Width code (log2 of live lanes) |
| subcol_i | input | 4 | Sub-column address from the column command |
| wdata_i | input | 256 | Write packet, lane L slot t at bit 16L+t |
| mask_i | input | 8 | Byte mask, 1 suppresses the byte |
| valid_o | output | 1 | Registered strobe |
| core_data_o | output | 256 | Internal write bus, set s slot t at bit 16s+t |
| core_we_o | output | 32 | Per-byte core write enables |

## Verification
The hardest effect to observe is that ignored inputs really are ignored. These are the low sub-column bits and the lanes above the active width. A fault there only shows when those inputs differ while everything else stays the same. The bench sweeps every width code against every sub-column value, with pseudo-random data in all 16 lanes and several masks, so ignored bits take both values. For x2 it also replays each packet with the upper lanes and sub-column bit 0 changed, and requires identical outputs.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int unsigned SETS    = 16;
  localparam int unsigned SLOTS   = 16;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned WIDTH_W = 3;
  localparam int unsigned SC_W    = $clog2(SETS);
  localparam int unsigned BUS_W   = SETS * SLOTS;
  localparam int unsigned BPS     = SLOTS / 8;
  localparam int unsigned BYTES   = SETS * BPS;
endpackage

// File: rtl/wdm_width_decode.sv
module wdm_width_decode #(
  parameter int unsigned WIDTH_W = wdm_pkg::WIDTH_W,
  parameter int unsigned SC_W    = wdm_pkg::SC_W
) (
  input  logic [WIDTH_W-1:0] width_i,
  output logic [WIDTH_W-1:0] lg_o,
  output logic               legal_o
);
  // codes 0..SC_W are log2(lanes); anything above is reserved
  always_comb begin
    legal_o = (32'(width_i) <= SC_W);
    lg_o    = legal_o ? width_i : '0;
  end
endmodule

// File: rtl/wdm_place.sv
module wdm_place #(
  parameter int unsigned SETS    = wdm_pkg::SETS,
  parameter int unsigned SLOTS   = wdm_pkg::SLOTS,
  parameter int unsigned WIDTH_W = wdm_pkg::WIDTH_W,
  localparam int unsigned SC_W   = $clog2(SETS),
  localparam int unsigned BUS_W  = SETS * SLOTS
) (
  input  logic [WIDTH_W-1:0] lg_i,
  input  logic               legal_i,
  input  logic [SC_W-1:0]    subcol_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [SETS-1:0]    sel_o,
  output logic [BUS_W-1:0]   data_o
);
  logic [SC_W-1:0] blk;
  logic [SC_W-1:0] lane_msk;

  always_comb begin
    blk      = subcol_i >> lg_i;
    lane_msk = SC_W'((1 << lg_i) - 1);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [SC_W-1:0] lane;
    always_comb begin
      lane      = SC_W'(s) & lane_msk;
      sel_o[s]  = legal_i && ((SC_W'(s) >> lg_i) == blk);
      data_o[s*SLOTS +: SLOTS] = sel_o[s] ? wdata_i[int'(lane)*SLOTS +: SLOTS] : '0;
    end
  end
endmodule

// File: rtl/wdm_mask_gen.sv
module wdm_mask_gen #(
  parameter int unsigned SETS   = wdm_pkg::SETS,
  parameter int unsigned SLOTS  = wdm_pkg::SLOTS,
  parameter int unsigned MASK_W = wdm_pkg::MASK_W,
  localparam int unsigned BPS   = SLOTS / 8,
  localparam int unsigned BYTES = SETS * BPS
) (
  input  logic              valid_i,
  input  logic [SETS-1:0]   sel_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [BYTES-1:0]  we_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign we_o[b] = valid_i & sel_i[b / BPS] & ~mask_i[b % MASK_W];
  end
endmodule

// File: rtl/wdm_write_demux.sv
module wdm_write_demux #(
  parameter int unsigned SETS    = wdm_pkg::SETS,
  parameter int unsigned SLOTS   = wdm_pkg::SLOTS,
  parameter int unsigned MASK_W  = wdm_pkg::MASK_W,
  parameter int unsigned WIDTH_W = wdm_pkg::WIDTH_W,
  localparam int unsigned SC_W   = $clog2(SETS),
  localparam int unsigned BUS_W  = SETS * SLOTS,
  localparam int unsigned BYTES  = SETS * (SLOTS / 8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [SC_W-1:0]    subcol_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic               valid_o,
  output logic [BUS_W-1:0]   core_data_o,
  output logic [BYTES-1:0]   core_we_o
);
  logic [WIDTH_W-1:0] lg;
  logic               legal;
  logic [SETS-1:0]    sel;
  logic [BUS_W-1:0]   placed;
  logic [BYTES-1:0]   we_d;

  wdm_width_decode #(.WIDTH_W(WIDTH_W), .SC_W(SC_W)) u_dec (
    .width_i (width_i),
    .lg_o    (lg),
    .legal_o (legal)
  );

  wdm_place #(.SETS(SETS), .SLOTS(SLOTS), .WIDTH_W(WIDTH_W)) u_place (
    .lg_i     (lg),
    .legal_i  (legal),
    .subcol_i (subcol_i),
    .wdata_i  (wdata_i),
    .sel_o    (sel),
    .data_o   (placed)
  );

  wdm_mask_gen #(.SETS(SETS), .SLOTS(SLOTS), .MASK_W(MASK_W)) u_mask (
    .valid_i (valid_i),
    .sel_i   (sel),
    .mask_i  (mask_i),
    .we_o    (we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      core_data_o <= '0;
      core_we_o   <= '0;
    end else begin
      valid_o     <= valid_i;
      core_data_o <= valid_i ? placed : '0;
      core_we_o   <= we_d;
    end
  end
endmodule

// File: rtl/wdm_write_demux_chk.sv
module wdm_write_demux_chk #(
  parameter int unsigned SETS    = wdm_pkg::SETS,
  parameter int unsigned SLOTS   = wdm_pkg::SLOTS,
  parameter int unsigned MASK_W  = wdm_pkg::MASK_W,
  parameter int unsigned WIDTH_W = wdm_pkg::WIDTH_W,
  localparam int unsigned SC_W   = $clog2(SETS),
  localparam int unsigned BUS_W  = SETS * SLOTS,
  localparam int unsigned BPS    = SLOTS / 8,
  localparam int unsigned BYTES  = SETS * BPS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [WIDTH_W-1:0] width_i,
  input logic [SC_W-1:0]    subcol_i,
  input logic [BUS_W-1:0]   wdata_i,
  input logic [MASK_W-1:0]  mask_i,
  input logic               valid_o,
  input logic [BUS_W-1:0]   core_data_o,
  input logic [BYTES-1:0]   core_we_o
);
  p_strobe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_strobe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && core_we_o == '0 && core_data_o == '0));
  p_full_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && 32'(width_i) == SC_W && mask_i == '0) |=> (&core_we_o));
  p_block_size_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && 32'(width_i) <= SC_W && mask_i == '0)
      |=> ($countones(core_we_o) == (BPS << $past(width_i))));
  p_mask_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((core_we_o & {(BYTES/MASK_W){$past(mask_i)}}) == '0));
  p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && 32'(width_i) > SC_W) |=> (core_we_o == '0 && core_data_o == '0));
endmodule

bind wdm_write_demux wdm_write_demux_chk u_chk (.*);

// File: tb/sim_wdm_write_demux.sv
`timescale 1ns/1ps
module sim_wdm_write_demux;
  localparam int SETS = 16, SLOTS = 16, BUS = 256, BYTES = 32, CLK_NS = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [2:0]       width = '0;
  logic [3:0]       subcol = '0;
  logic [BUS-1:0]   wdata = '0;
  logic [7:0]       mask = '0;
  logic             valid_o;
  logic [BUS-1:0]   data_o;
  logic [BYTES-1:0] we_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_NS/2) clk = ~clk;

  wdm_write_demux u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .width_i(width),
    .subcol_i(subcol), .wdata_i(wdata), .mask_i(mask),
    .valid_o(valid_o), .core_data_o(data_o), .core_we_o(we_o)
  );

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic chk(input string tag, input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int w);
    case (w)
      4: return "R3";
      3: return "R4";
      2: return "R5";
      1: return "R6";
      0: return "R7";
      default: return "R10";
    endcase
  endfunction

  // expected placement computed from the lane/block arithmetic of the requirements
  task automatic expect_out(input int w, input int sc, input logic [BUS-1:0] d, input logic [7:0] m,
                            output logic [BUS-1:0] ed, output logic [BYTES-1:0] ew,
                            output logic [SETS-1:0] in_blk);
    int lanes;
    ed = '0; ew = '0; in_blk = '0;
    if (w <= 4) begin
      lanes = 1 << w;
      for (int s = 0; s < SETS; s++) begin
        if (s / lanes == sc / lanes) begin
          in_blk[s] = 1'b1;
          ed[s*SLOTS +: SLOTS] = d[(s % lanes)*SLOTS +: SLOTS];
          for (int h = 0; h < 2; h++) ew[2*s+h] = ~m[(2*s+h) % 8];
        end
      end
    end
  endtask

  task automatic drive(input int w, input int sc, input logic [BUS-1:0] d, input logic [7:0] m);
    @(negedge clk);
    valid = 1'b1; width = 3'(w); subcol = 4'(sc); wdata = d; mask = m;
    @(negedge clk);
  endtask

  task automatic run_vec(input int w, input int sc, input logic [BUS-1:0] d, input logic [7:0] m);
    logic [BUS-1:0] ed, outside;
    logic [BYTES-1:0] ew;
    logic [SETS-1:0] ib;
    drive(w, sc, d, m);
    expect_out(w, sc, d, m, ed, ew, ib);
    outside = '0;
    for (int s = 0; s < SETS; s++) if (!ib[s]) outside[s*SLOTS +: SLOTS] = '1;
    chk("R2 valid_o", BUS'(valid_o), BUS'(1));
    chk(tag_of(w), data_o, ed);
    chk("R9 we", BUS'(we_o), BUS'(ew));
    chk("R8 outside", data_o & outside, '0);
  endtask

  initial begin
    logic [BUS-1:0] d, d2, first;
    logic [BYTES-1:0] first_we;
    logic [7:0] masks [4];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5; masks[3] = 8'h3C;
    #(CLK_NS*2);
    chk("R1 reset valid", BUS'(valid_o), '0);
    chk("R1 reset data", data_o, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle we", BUS'(we_o), '0);

    for (int w = 0; w < 8; w++)
      for (int sc = 0; sc < 16; sc++)
        for (int mi = 0; mi < 4; mi++) begin
          for (int k = 0; k < 8; k++) begin seed = nxt(seed); d[k*32 +: 32] = seed; end
          run_vec(w, sc, d, masks[mi]);
        end

    // x2: lanes 2..15 and subcol bit 0 have no effect (R6)
    for (int sc = 0; sc < 16; sc += 2) begin
      for (int k = 0; k < 8; k++) begin seed = nxt(seed); d[k*32 +: 32] = seed; end
      drive(1, sc, d, 8'h5A);
      first = data_o; first_we = we_o;
      d2 = d;
      for (int k = 1; k < 8; k++) begin seed = nxt(seed); d2[k*32 +: 32] = seed; end
      drive(1, sc + 1, d2, 8'h5A);
      chk("R6 ignored data", data_o, first);
      chk("R6 ignored we", BUS'(we_o), BUS'(first_we));
    end

    // strobe low: nothing written next cycle (R2)
    @(negedge clk); valid = 1'b0; width = 3'd4; mask = '0;
    @(negedge clk);
    chk("R2 idle valid", BUS'(valid_o), '0);
    chk("R2 idle we", BUS'(we_o), '0);
    chk("R2 idle data", data_o, '0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule